// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Staged Page Writes

This block is the slave side of a two-wire serial bus in front of a 256 x 8 non-volatile array. It samples SCL and SDA with the system clock and finds start and stop conditions. It then decodes a control byte, a word address and any data bytes that follow, and acknowledges each byte by pulling SDA low during the ninth clock. The array itself sits outside the block behind a simple synchronous memory port. A read returns data one clock after the address is presented.

Write data is not sent to the array as it arrives. It is held in an eight-byte staging buffer tied to one aligned page, and it goes to the array only when the master closes the transfer with a stop condition. After a commit, the block models the self-timed programming cycle as a fixed count of busy clocks. During that count it ignores its own address, so a host can poll for completion. A write-protect pin has no effect until location 7Fh has been written once. After that, while the pin is high, writes are acknowledged but the array is not changed.

Top module: `tw_eeprom_slave`

## Requirements
- R1: The block answers only to a control byte whose upper seven bits are 1010000; bit 0 of that byte selects read (1) or write (0). Any other control byte gets no acknowledge, and the block keeps SDA released until the next start condition.
- R2: Once addressed, the block acknowledges every byte it receives (control, word address, data) by driving SDA low for the ninth SCL pulse. It changes SDA only after an SCL falling edge, a start or a stop.
- R3: In a write, the byte after the control byte loads the address pointer and later bytes go into the staging buffer. The array is not written before the stop condition, and the buffered bytes reach the array after the stop.
- R4: More than eight data bytes wrap within the aligned eight-byte page: only the low three address bits advance, and a later byte replaces the earlier byte held for the same location.
- R5: A repeated start that arrives before the stop discards any buffered data bytes, so nothing is committed and no busy period begins.
- R6: A random read works as follows. A write-type control byte and a word address set the pointer, then a repeated start and a read-type control byte return the byte stored at that address.
- R7: In a read, an acknowledge from the master makes the block send the byte at the next address. The pointer wraps from FFh to 00h.
- R8: When the master does not acknowledge a read byte, the block releases SDA and sends nothing more in that transfer.
- R9: After a commit, the block does not acknowledge its address for the busy period (the eight commit clocks plus BUSY_CYC clocks). After that period it acknowledges normally.
- R10: The protect pin has no effect until location 7Fh has been written. After that write, a write made while the pin is high is acknowledged but leaves the array unchanged, and a write made while the pin is low is committed.
- R11: During and just after reset, SDA is released and no array write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| wp_i | input | 1 | Write-protect pin, active once armed |
| mem_addr | output | 8 | Array address (read pointer, or commit address while committing) |
| mem_we | output | 1 | Array write strobe, one byte per clock |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one clock after mem_addr |

## Verification
Two functions of this block can act in the same cycle: decoding a control byte and finishing the commit-plus-busy timer. The bench provokes this by polling with a control byte right after a stop that follows a full page write. It expects no acknowledge while the timer still runs and an acknowledge after the period ends. The staging buffer and the array port are judged together. The bench reads its own memory model through the port before and after the stop, and it checks that a repeated start leaves nothing to commit and starts no busy period. Protection arming and write gating are checked by following a write to 7Fh with a protected write to a neighbouring location.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int PAGE_BITS = 3;
  localparam int PAGE_LEN  = 1 << PAGE_BITS;
  localparam int DEV_W     = 7;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} bus_st_t;
  typedef enum logic [1:0] {P_CTRL, P_WADDR, P_DATA, P_READ} phase_t;

  // advance only the in-page offset (write staging)
  function automatic addr_t page_step(addr_t a);
    addr_t r;
    r = a;
    r[PAGE_BITS-1:0] = a[PAGE_BITS-1:0] + 1'b1;
    return r;
  endfunction

  // advance across the whole array (sequential read)
  function automatic addr_t seq_step(addr_t a);
    return addr_t'(a + 1'b1);
  endfunction

  function automatic logic ctrl_hits(byte_t c, logic [DEV_W-1:0] id);
    return c[DATA_W-1:1] == id;
  endfunction
endpackage

// File: rtl/tw_line_mon.sv
module tw_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_m, sda_m;
  logic       scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_d <= scl_m[1];
      sda_d <= sda_m[1];
    end
  end

  assign scl_s    = scl_m[1];
  assign sda_s    = sda_m[1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_page_stage.sv
module tw_page_stage
  import tw_eeprom_pkg::*;
#(
  parameter int BUSY_CYC = 400
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear_i,
  input  logic  load_i,
  input  addr_t load_addr_i,
  input  byte_t load_data_i,
  input  logic  commit_i,
  input  logic  wp_i,
  output logic  busy_o,
  output logic  committing_o,
  output logic  armed_o,
  output addr_t wr_addr_o,
  output byte_t wr_data_o,
  output logic  wr_en_o
);
  localparam int    TW      = $clog2(BUSY_CYC + 1);
  localparam addr_t ARM_LOC = addr_t'(8'h7F);

  byte_t                        slot_q [PAGE_LEN];
  logic [PAGE_LEN-1:0]          valid_q;
  logic [ADDR_W-PAGE_BITS-1:0]  base_q;
  logic [PAGE_BITS-1:0]         idx_q;
  logic                         committing_q, armed_q;
  logic [TW-1:0]                timer_q;
  logic                         last_slot;

  for (genvar g = 0; g < PAGE_LEN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (load_i && load_addr_i[PAGE_BITS-1:0] == PAGE_BITS'(g))
        slot_q[g] <= load_data_i;
    end
  end

  assign last_slot = committing_q && (idx_q == PAGE_BITS'(PAGE_LEN - 1));
  assign wr_addr_o = {base_q, idx_q};
  assign wr_data_o = slot_q[idx_q];
  assign wr_en_o   = committing_q & valid_q[idx_q] & ~(armed_q & wp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q      <= '0;
      base_q       <= '0;
      idx_q        <= '0;
      committing_q <= 1'b0;
      timer_q      <= '0;
      armed_q      <= 1'b0;
    end else begin
      if (last_slot)
        valid_q <= '0;
      else if (clear_i && !committing_q)
        valid_q <= '0;
      else if (load_i)
        valid_q[load_addr_i[PAGE_BITS-1:0]] <= 1'b1;

      if (load_i)
        base_q <= load_addr_i[ADDR_W-1:PAGE_BITS];

      if (!committing_q && commit_i && |valid_q) begin
        committing_q <= 1'b1;
        idx_q        <= '0;
      end else if (committing_q) begin
        idx_q <= idx_q + 1'b1;
        if (last_slot) begin
          committing_q <= 1'b0;
          timer_q      <= TW'(BUSY_CYC);
        end
      end else if (timer_q != '0) begin
        timer_q <= timer_q - 1'b1;
      end

      if (wr_en_o && wr_addr_o == ARM_LOC)
        armed_q <= 1'b1;
    end
  end

  assign busy_o       = committing_q | (timer_q != '0);
  assign committing_o = committing_q;
  assign armed_o      = armed_q;
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ID   = 7'b1010000,
  parameter int               BUSY_CYC = 400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        wp_i,
  output logic [7:0]  mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  logic    sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  bus_st_t st;
  phase_t  ph;
  logic [3:0] bcnt;
  byte_t   shreg, txreg;
  addr_t   ptr;
  logic    sda_oe_q, mack;
  logic    busy, committing, armed, wr_en;
  addr_t   wr_addr;
  byte_t   wr_data;

  // named internal events
  logic byte_eval, ctrl_eval, ctrl_ok, buf_load;
  assign byte_eval = (st == S_RX) && scl_fall && (bcnt == 4'd8);
  assign ctrl_eval = byte_eval && (ph == P_CTRL);
  assign ctrl_ok   = ctrl_hits(shreg, DEV_ID) && !busy;
  assign buf_load  = byte_eval && (ph == P_DATA);

  tw_line_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tw_page_stage #(.BUSY_CYC(BUSY_CYC)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .clear_i(start_ev), .load_i(buf_load), .load_addr_i(ptr),
    .load_data_i(shreg), .commit_i(stop_ev), .wp_i(wp_i),
    .busy_o(busy), .committing_o(committing), .armed_o(armed),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_en_o(wr_en)
  );

  assign mem_addr  = committing ? wr_addr : ptr;
  assign mem_we    = wr_en;
  assign mem_wdata = wr_data;
  assign sda_oe    = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= P_CTRL;
      bcnt     <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      sda_oe_q <= 1'b0;
      mack     <= 1'b0;
    end else if (start_ev) begin
      st       <= S_RX;
      ph       <= P_CTRL;
      bcnt     <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_ev) begin
      st       <= S_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (st)
        S_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            bcnt  <= bcnt + 4'd1;
          end else if (ctrl_eval) begin
            bcnt <= '0;
            if (ctrl_ok) begin
              st       <= S_ACK;
              sda_oe_q <= 1'b1;
              ph       <= shreg[0] ? P_READ : P_WADDR;
            end else begin
              st <= S_IDLE;
            end
          end else if (byte_eval) begin
            bcnt     <= '0;
            st       <= S_ACK;
            sda_oe_q <= 1'b1;
            if (ph == P_WADDR) begin
              ptr <= shreg;
              ph  <= P_DATA;
            end else begin
              ptr <= page_step(ptr);
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bcnt <= '0;
            if (ph == P_READ) begin
              st       <= S_TX;
              txreg    <= mem_rdata;
              sda_oe_q <= ~mem_rdata[DATA_W-1];
              ptr      <= seq_step(ptr);
            end else begin
              st       <= S_RX;
              sda_oe_q <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              st       <= S_MACK;
              sda_oe_q <= 1'b0;
            end else begin
              txreg    <= {txreg[DATA_W-2:0], 1'b0};
              sda_oe_q <= ~txreg[DATA_W-2];
              bcnt     <= bcnt + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            bcnt <= '0;
            if (mack) begin
              st       <= S_TX;
              txreg    <= mem_rdata;
              sda_oe_q <= ~mem_rdata[DATA_W-1];
              ptr      <= seq_step(ptr);
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk
  import tw_eeprom_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    sda_oe,
  input logic    mem_we,
  input logic    scl_fall,
  input logic    start_ev,
  input logic    stop_ev,
  input logic    ctrl_eval,
  input logic    busy,
  input logic    armed,
  input bus_st_t st
);
  // R2: SDA drive moves only after a low-going SCL edge, start or stop
  a_r2_sda_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

  // R1: a start condition always leaves SDA released
  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  // R3: the array is written only while no transfer is in progress
  a_r3_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> st == S_IDLE);

  // R9: a control byte seen while busy gets no acknowledge
  a_r9_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_eval && busy) |=> !sda_oe);

  // R10: once armed, protection stays armed
  a_r10_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

bind tw_eeprom_slave tw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .mem_we(mem_we),
  .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
  .ctrl_eval(ctrl_eval), .busy(busy), .armed(armed), .st(st)
);

// File: tb/sim_tw_eeprom_slave.sv
module sim_tw_eeprom_slave;
  localparam int CLK_PER = 10;
  localparam int Q       = 6;
  localparam int BUSY    = 400;
  localparam int NVEC    = 6;
  // {word address, data}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00_3C, 16'h01_C3, 16'h7E_00, 16'h80_FF, 16'hA5_5A, 16'hFF_81
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_line;
  logic [7:0] mem [256];
  logic [7:0] exp_m [256];
  int total = 0, bad = 0, we_in_reset = 0;
  logic done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tw_eeprom_slave #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (!rst_n && mem_we) we_in_reset++;
  end

  task automatic qw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b0; qw(Q); scl_m = 1'b0; qw(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b1; qw(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(Q); scl_m = 1'b1; qw(2*Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q);
    acked = !sda_line;
    qw(Q); scl_m = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(Q); scl_m = 1'b1; qw(Q); b[i] = sda_line; qw(Q); scl_m = 1'b0;
    end
    qw(Q); sda_m = !give_ack; qw(Q); scl_m = 1'b1; qw(2*Q); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic wr_burst(input logic [7:0] a, input int n, input logic [7:0] d0,
                          input logic do_stop, output int acks);
    logic ak;
    acks = 0;
    bus_start;
    put_byte(8'hA0, ak); acks += int'(ak);
    put_byte(a, ak);     acks += int'(ak);
    for (int k = 0; k < n; k++) begin
      put_byte(8'(d0 + k), ak); acks += int'(ak);
    end
    if (do_stop) bus_stop;
  endtask

  task automatic rd_burst(input logic [7:0] a, input int n, input string req);
    logic ak;
    logic [7:0] b;
    bus_start;
    put_byte(8'hA0, ak); chk({req, " ctrl-w ack"}, ak, 1'b1);
    put_byte(a, ak);     chk({req, " addr ack"}, ak, 1'b1);
    bus_start;
    put_byte(8'hA1, ak); chk({req, " ctrl-r ack"}, ak, 1'b1);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, b);
      chk({req, " data"}, b, exp_m[8'(a + k)]);
    end
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int acks;
    logic ak;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 7 + 3);
      exp_m[i] = 8'(i * 7 + 3);
    end
    qw(5);
    // R11: reset state
    chk("R11 sda released in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    qw(3);
    chk("R11 sda released after reset", sda_oe, 1'b0);
    chk("R11 no array write in reset", we_in_reset, 0);

    // R3 / R6 / R2: vector table of single-byte writes read back
    for (int v = 0; v < NVEC; v++) begin
      wr_burst(VEC[v][15:8], 1, VEC[v][7:0], 1'b1, acks);
      chk("R2 all bytes acked", acks, 3);
      exp_m[VEC[v][15:8]] = VEC[v][7:0];
      qw(BUSY + 50);
      rd_burst(VEC[v][15:8], 1, "R6 random read");
    end

    // R1: foreign control byte ignored, stays off the bus
    bus_start;
    put_byte(8'hA2, ak); chk("R1 foreign address nack", ak, 1'b0);
    put_byte(8'h00, ak); chk("R1 silent until next start", ak, 1'b0);
    bus_stop;

    // R3 / R9: page write, staged until stop, then busy polling
    wr_burst(8'h20, 8, 8'h50, 1'b0, acks);
    chk("R2 page bytes acked", acks, 10);
    chk("R3 array untouched before stop", mem[8'h20], exp_m[8'h20]);
    bus_stop;
    for (int k = 0; k < 8; k++) exp_m[8'h20 + k] = 8'(8'h50 + k);
    bus_start;
    put_byte(8'hA0, ak); chk("R9 poll nack while busy", ak, 1'b0);
    bus_stop;
    chk("R3 committed after stop", mem[8'h27], 8'h57);
    qw(BUSY + 50);
    bus_start;
    put_byte(8'hA0, ak); chk("R9 poll ack after busy", ak, 1'b1);
    bus_stop;
    rd_burst(8'h20, 8, "R7 sequential read");

    // R4: ten bytes starting mid-page wrap inside the page
    wr_burst(8'h44, 10, 8'h80, 1'b1, acks);
    chk("R4 wrapped bytes acked", acks, 12);
    for (int k = 0; k < 10; k++) exp_m[8'h40 | ((4 + k) & 7)] = 8'(8'h80 + k);
    qw(BUSY + 50);
    rd_burst(8'h40, 8, "R4 page wrap");

    // R5: repeated start discards staged data, no busy period
    wr_burst(8'h60, 1, 8'h11, 1'b0, acks);
    bus_start;
    bus_stop;
    rd_burst(8'h60, 1, "R5 discarded");

    // R7: pointer wraps FFh -> 00h
    rd_burst(8'hFE, 4, "R7 pointer wrap");

    // R8: master nack ends transmission
    bus_start;
    put_byte(8'hA0, ak);
    put_byte(8'h10, ak);
    bus_start;
    put_byte(8'hA1, ak);
    get_byte(1'b0, b); chk("R8 byte before nack", b, exp_m[8'h10]);
    get_byte(1'b0, b); chk("R8 bus released after nack", b, 8'hFF);
    bus_stop;

    // R10: protect pin inert until 7Fh written
    wp = 1'b1;
    wr_burst(8'h30, 1, 8'h5A, 1'b1, acks);
    exp_m[8'h30] = 8'h5A;
    qw(BUSY + 50);
    wr_burst(8'h7F, 1, 8'h99, 1'b1, acks);
    exp_m[8'h7F] = 8'h99;
    qw(BUSY + 50);
    wr_burst(8'h31, 1, 8'h77, 1'b1, acks);
    chk("R10 protected write still acked", acks, 3);
    qw(BUSY + 50);
    rd_burst(8'h30, 2, "R10 unarmed write kept, protected write blocked");
    wp = 1'b0;
    wr_burst(8'h31, 1, 8'h66, 1'b1, acks);
    exp_m[8'h31] = 8'h66;
    qw(BUSY + 50);
    rd_burst(8'h31, 1, "R10 write with pin low");
    rd_burst(8'h7F, 1, "R10 arming write");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule